// File: doc/BRIEF.md
# ADC Channel Scan Controller

This block sits between a 16-bit register bus and a 12-bit successive-approximation converter core. Software picks a set of channels through a bitmap register and starts a scan. The controller then converts the picked channels one at a time, in ascending index order. It uses a start/done/data handshake with the core, and it stores each 12-bit value right-aligned in that channel's own 16-bit result register.

A scan is either a single pass or a repeating pass that continues until software clears the start bit. Three sources can start a scan: a software write, a synchronous trigger pulse, and an active-low external pin. The pin is asynchronous and is resynchronised inside the block. Each hardware source has its own enable bit. An interrupt level marks the end of a scan.

A calibration register sends a one-cycle request to the core. It then reports the core's completion as a ready flag and the core's pass/fail result as an error flag. While calibration runs, the controller accepts no scan start.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, the control, channel-select, calibration and result registers all read 0, and `irq`, `core_start` and `cal_start` are low.
- R2: A scan converts each enabled channel exactly once, in ascending index order. The value returned by the core for channel n is readable at byte offset 0x20 + 2n, with bits 15:12 reading 0.
- R3: In single mode (control bits 14:13 = 00), the start bit (control bit 15) and the busy flag (control bit 0) both read 0 once the last enabled channel has been stored.
- R4: `irq` rises at the end of a scan only when control bit 12 is 1. A control write that has bit 12 = 0 or bit 15 = 1 clears `irq` on the clock edge that takes the write.
- R5: A start requested while the channel-select register (offset 0x04, bit n = channel n) is 0 issues no conversion, leaves the start bit at 0 and does not raise `irq`.
- R6: In continuous mode (control bits 14:13 = 01), scans repeat back to back while the start bit stays 1. Writing the start bit to 0 lets the current scan finish and then stops.
- R7: A channel-select write made during a scan does not change that scan. It takes effect at the next scan start.
- R8: A one-cycle pulse on `sync_trig` starts a scan only when control bit 8 is 1 and the controller is idle. Otherwise it is ignored.
- R9: A falling edge on `ext_trig_n` starts a scan only when control bit 9 is 1 and the controller is idle. The pin goes through two synchronising flops and an edge detector, so `core_start` rises in the third cycle after the pin falls.
- R10: Writing 1 to bit 0 of the calibration register (offset 0x1F0) sends a one-cycle `cal_start`, clears the ready flag (bit 1) and sets the in-progress flag (bit 0). On `cal_done`, the ready flag is set and the error flag (bit 2) takes the value of `cal_fail`.
- R11: A scan start from any source is ignored while calibration is in progress.
- R12: Reads at offsets that map to no register, and at odd offsets inside the result range, return 0.
- R13: `core_start` is a one-cycle pulse. No new conversion is issued until the core has answered the previous one with `core_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Byte offset for register read and write |
| bus_wr | input | 1 | Write strobe; data is taken on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| sync_trig | input | 1 | Synchronous scan trigger pulse |
| ext_trig_n | input | 1 | Asynchronous active-low external trigger pin |
| irq | output | 1 | End-of-scan interrupt level |
| core_start | output | 1 | Conversion request to the converter core |
| core_chan | output | 4 | Channel index for the requested conversion |
| core_done | input | 1 | Conversion complete, with `core_data` valid |
| core_data | input | 12 | Conversion result from the core |
| cal_start | output | 1 | Calibration request pulse to the core |
| cal_done | input | 1 | Calibration complete |
| cal_fail | input | 1 | Calibration outcome, valid together with `cal_done` |

## Verification
A software start is taken on the edge that samples the write, and `core_start` is high for the whole of the next cycle. A falling edge on the pin reaches `core_start` three cycles later. A result register, the end-of-scan `irq` and the single-mode clearing of the start bit all change on the edge that samples `core_done` for the last enabled channel. `cal_start` is high in the cycle after the calibration write. The bench drives every input and samples every output on the falling clock edge, so each expected value is compared one half-cycle after the edge that produces it. The pin-latency check counts those falling edges explicitly. A scoreboard queue holds the expected channel order and is compared at each conversion request.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int MAX_CH   = 16;
    localparam int CH_IDX_W = $clog2(MAX_CH);
    localparam int REG_W    = 16;
    localparam int CONV_W   = 12;

    localparam int unsigned OFS_CTRL  = 'h000;
    localparam int unsigned OFS_CHSEL = 'h004;
    localparam int unsigned OFS_RES   = 'h020;
    localparam int unsigned OFS_CAL   = 'h1F0;

    localparam int B_START   = 15;
    localparam int B_MODE_HI = 14;
    localparam int B_MODE_LO = 13;
    localparam int B_IEN     = 12;
    localparam int B_XTEN    = 9;
    localparam int B_STEN    = 8;
    localparam int B_BUSY    = 0;
    localparam int B_CREQ    = 0;

    localparam logic [1:0] MODE_SINGLE = 2'b00;
    localparam logic [1:0] MODE_CONT   = 2'b01;

    typedef enum logic [1:0] {SEQ_IDLE, SEQ_ISSUE, SEQ_WAIT} seq_state_t;

    typedef struct packed {
        logic                found;
        logic [CH_IDX_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic       start;
        logic [1:0] mode;
        logic       ien;
        logic       xten;
        logic       sten;
    } ctrl_t;

    // lowest set bit of a channel bitmap
    function automatic pick_t pick_lowest(input logic [MAX_CH-1:0] m);
        pick_t p;
        p = '0;
        for (int i = MAX_CH - 1; i >= 0; i--) begin
            if (m[i]) begin
                p.found = 1'b1;
                p.idx   = CH_IDX_W'(i);
            end
        end
        return p;
    endfunction

    // bitmap of all channel positions strictly above idx
    function automatic logic [MAX_CH-1:0] above(input logic [CH_IDX_W-1:0] idx);
        logic [MAX_CH:0] t;
        t = (MAX_CH+1)'(1) << ({1'b0, idx} + 1'b1);
        t = t - (MAX_CH+1)'(1);
        return ~t[MAX_CH-1:0];
    endfunction

    function automatic logic is_cont(input logic [1:0] m);
        return m == MODE_CONT;
    endfunction

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync
    import adc_scan_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall
);
    // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[STAGES-1:0], pin_n};
    end

    assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];

    assert_edge_single_R9: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);
endmodule

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl
    import adc_scan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic cal_done,
    input  logic cal_fail,
    output logic cal_start,
    output logic busy,
    output logic ready,
    output logic err
);
    logic start_q, busy_q, ready_q, err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            busy_q  <= 1'b0;
            ready_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            start_q <= req && !busy_q;
            if (req && !busy_q) begin
                busy_q  <= 1'b1;
                ready_q <= 1'b0;
            end else if (busy_q && cal_done) begin
                busy_q  <= 1'b0;
                ready_q <= 1'b1;
                err_q   <= cal_fail;
            end
        end
    end

    assign cal_start = start_q;
    assign busy      = busy_q;
    assign ready     = ready_q;
    assign err       = err_q;

    assert_cal_clears_ready_R10: assert property (@(posedge clk) disable iff (rst)
        cal_start |-> (busy_q && !ready_q));
    assert_cal_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        cal_start |=> !cal_start);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic [MAX_CH-1:0]   mask_in,
    input  logic                rescan,
    output logic                busy,
    output logic                scan_end,
    output logic                core_start,
    output logic [CH_IDX_W-1:0] core_chan,
    input  logic                core_done,
    input  logic [CONV_W-1:0]   core_data,
    output logic                res_we,
    output logic [CH_IDX_W-1:0] res_idx,
    output logic [CONV_W-1:0]   res_data
);
    seq_state_t          state_q;
    logic [CH_IDX_W-1:0] cur_q;
    logic [MAX_CH-1:0]   snap_q;
    pick_t               first, nxt;

    always_comb begin
        first      = pick_lowest(mask_in);
        nxt        = pick_lowest(snap_q & above(cur_q));
        core_start = (state_q == SEQ_ISSUE);
        core_chan  = cur_q;
        res_we     = (state_q == SEQ_WAIT) && core_done;
        res_idx    = cur_q;
        res_data   = core_data;
        scan_end   = res_we && !nxt.found;
        busy       = (state_q != SEQ_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cur_q   <= '0;
            snap_q  <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (go && first.found) begin
                    snap_q  <= mask_in;
                    cur_q   <= first.idx;
                    state_q <= SEQ_ISSUE;
                end
                SEQ_ISSUE: state_q <= SEQ_WAIT;
                SEQ_WAIT: if (core_done) begin
                    if (nxt.found) begin
                        cur_q   <= nxt.idx;
                        state_q <= SEQ_ISSUE;
                    end else if (rescan && first.found) begin
                        snap_q  <= mask_in;
                        cur_q   <= first.idx;
                        state_q <= SEQ_ISSUE;
                    end else begin
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assert_conv_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start);
    assert_chan_enabled_R2: assert property (@(posedge clk) disable iff (rst)
        core_start |-> snap_q[core_chan]);
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int NUM_CH   = 16,
    parameter int SYNC_STG = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic                sync_trig,
    input  logic                ext_trig_n,
    output logic                irq,
    output logic                core_start,
    output logic [CH_IDX_W-1:0] core_chan,
    input  logic                core_done,
    input  logic [CONV_W-1:0]   core_data,
    output logic                cal_start,
    input  logic                cal_done,
    input  logic                cal_fail
);
    localparam logic [MAX_CH:0]     CH_ONE   = (MAX_CH+1)'(1);
    localparam logic [MAX_CH:0]     CH_FULL  = (CH_ONE << NUM_CH) - CH_ONE;
    localparam logic [MAX_CH-1:0]   CH_VALID = CH_FULL[MAX_CH-1:0];
    localparam logic [ADDR_W-1:0]   A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0]   A_CHSEL  = ADDR_W'(OFS_CHSEL);
    localparam logic [ADDR_W-1:0]   A_CAL    = ADDR_W'(OFS_CAL);
    localparam logic [ADDR_W-1:0]   A_RES_LO = ADDR_W'(OFS_RES);
    localparam logic [ADDR_W-1:0]   A_RES_HI = ADDR_W'(OFS_RES + 2 * NUM_CH);

    ctrl_t               ctrl_q;
    logic                start_d, irq_q, irq_d;
    logic [MAX_CH-1:0]   chsel_q;
    logic [CONV_W-1:0]   res_q [NUM_CH];

    logic wr_ctrl, wr_chsel, wr_cal;
    logic ext_fall, hw_trig, sw_trig, go_ok, go, cal_req;
    logic seq_busy, scan_end, res_we;
    logic [CH_IDX_W-1:0] res_idx;
    logic [CONV_W-1:0]   res_data;
    logic cal_busy, cal_ready, cal_err;
    logic [ADDR_W-1:0]   roff;
    logic                res_hit;

    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_chsel = bus_wr && (bus_addr == A_CHSEL);
    assign wr_cal   = bus_wr && (bus_addr == A_CAL);

    adc_trig_sync #(.STAGES(SYNC_STG)) i_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_n (ext_trig_n),
        .fall  (ext_fall)
    );

    assign hw_trig = (sync_trig && ctrl_q.sten) || (ext_fall && ctrl_q.xten);
    assign sw_trig = wr_ctrl && bus_wdata[B_START];
    assign go_ok   = !seq_busy && !cal_busy && (chsel_q != '0);
    assign go      = go_ok && (sw_trig || hw_trig);
    assign cal_req = wr_cal && bus_wdata[B_CREQ] && !seq_busy && !go;

    adc_scan_seq i_seq (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .mask_in    (chsel_q),
        .rescan     (is_cont(ctrl_q.mode) && ctrl_q.start),
        .busy       (seq_busy),
        .scan_end   (scan_end),
        .core_start (core_start),
        .core_chan  (core_chan),
        .core_done  (core_done),
        .core_data  (core_data),
        .res_we     (res_we),
        .res_idx    (res_idx),
        .res_data   (res_data)
    );

    adc_cal_ctrl i_cal (
        .clk       (clk),
        .rst       (rst),
        .req       (cal_req),
        .cal_done  (cal_done),
        .cal_fail  (cal_fail),
        .cal_start (cal_start),
        .busy      (cal_busy),
        .ready     (cal_ready),
        .err       (cal_err)
    );

    always_comb begin
        start_d = ctrl_q.start;
        if (wr_ctrl) start_d = bus_wdata[B_START] && (seq_busy ? ctrl_q.start : go_ok);
        else if (go) start_d = 1'b1;
        if (scan_end && (!is_cont(ctrl_q.mode) || chsel_q == '0)) start_d = 1'b0;

        irq_d = irq_q;
        if (wr_ctrl && (!bus_wdata[B_IEN] || bus_wdata[B_START])) irq_d = 1'b0;
        if (scan_end && ctrl_q.ien) irq_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            irq_q   <= 1'b0;
            chsel_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.mode <= bus_wdata[B_MODE_HI:B_MODE_LO];
                ctrl_q.ien  <= bus_wdata[B_IEN];
                ctrl_q.xten <= bus_wdata[B_XTEN];
                ctrl_q.sten <= bus_wdata[B_STEN];
            end
            ctrl_q.start <= start_d;
            irq_q        <= irq_d;
            if (wr_chsel) chsel_q <= bus_wdata[MAX_CH-1:0] & CH_VALID;
        end
    end

    always_ff @(posedge clk) begin
        for (int g = 0; g < NUM_CH; g++) begin
            if (rst)                                         res_q[g] <= '0;
            else if (res_we && res_idx == CH_IDX_W'(g))      res_q[g] <= res_data;
        end
    end

    assign irq     = irq_q;
    assign roff    = bus_addr - A_RES_LO;
    assign res_hit = (bus_addr >= A_RES_LO) && (bus_addr < A_RES_HI) && !bus_addr[0];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata[B_START]             = ctrl_q.start;
            bus_rdata[B_MODE_HI:B_MODE_LO] = ctrl_q.mode;
            bus_rdata[B_IEN]               = ctrl_q.ien;
            bus_rdata[B_XTEN]              = ctrl_q.xten;
            bus_rdata[B_STEN]              = ctrl_q.sten;
            bus_rdata[B_BUSY]              = seq_busy;
        end else if (bus_addr == A_CHSEL) begin
            bus_rdata[MAX_CH-1:0] = chsel_q;
        end else if (bus_addr == A_CAL) begin
            bus_rdata[2:0] = {cal_err, cal_ready, cal_busy};
        end else if (res_hit) begin
            bus_rdata[CONV_W-1:0] = res_q[roff[CH_IDX_W:1]];
        end
    end

    assert_irq_from_scan_end_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(scan_end && ctrl_q.ien));
    assert_single_clears_start_R3: assert property (@(posedge clk) disable iff (rst)
        (scan_end && ctrl_q.mode == MODE_SINGLE && !wr_ctrl) |=> !ctrl_q.start);
    assert_empty_mask_no_start_R5: assert property (@(posedge clk) disable iff (rst)
        (sw_trig && chsel_q == '0 && !seq_busy) |=> (!ctrl_q.start && !seq_busy));
    assert_cal_excludes_scan_R11: assert property (@(posedge clk) disable iff (rst)
        cal_busy |-> !seq_busy);
endmodule

// File: tb/test_adc_scan_ctrl.sv
`timescale 1ns/1ps
module test_adc_scan_ctrl;
    import adc_scan_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sync_trig = 1'b0;
    logic        ext_trig_n = 1'b1;
    logic        irq;
    logic        core_start;
    logic [3:0]  core_chan;
    logic        core_done = 1'b0;
    logic [11:0] core_data = '0;
    logic        cal_start;
    logic        cal_done = 1'b0;
    logic        cal_fail = 1'b0;

    always #2.5 clk = ~clk;

    adc_scan_ctrl i_adc_scan_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_trig(sync_trig),
        .ext_trig_n(ext_trig_n), .irq(irq), .core_start(core_start),
        .core_chan(core_chan), .core_done(core_done), .core_data(core_data),
        .cal_start(cal_start), .cal_done(cal_done), .cal_fail(cal_fail)
    );

    int          n_checks = 0;
    int          n_errs   = 0;
    int          exp_q[$];
    int          conv_total = 0;
    logic [11:0] exp_res [16];
    logic [7:0]  data_cnt = '0;
    bit          fail_sel = 1'b0;

    task automatic eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    endtask

    // converter core model and scoreboard monitor
    initial begin
        for (int i = 0; i < 16; i++) exp_res[i] = '0;
        forever begin
            @(negedge clk);
            core_done = 1'b0;
            if (core_start) begin
                int ch;
                ch = int'(core_chan);
                conv_total++;
                if (exp_q.size() == 0) eq("R2 unexpected conversion", ch, -1);
                else eq("R2 scan order", ch, exp_q.pop_front());
                @(negedge clk);
                eq("R13 core_start one cycle", int'(core_start), 0);
                repeat (2) @(negedge clk);
                data_cnt++;
                core_data   = {ch[3:0], data_cnt};
                exp_res[ch] = {ch[3:0], data_cnt};
                core_done   = 1'b1;
            end
        end
    end

    // calibration model
    initial begin
        forever begin
            @(negedge clk);
            cal_done = 1'b0;
            if (cal_start) begin
                repeat (12) @(negedge clk);
                cal_fail = fail_sel;
                cal_done = 1'b1;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        eq("watchdog expired", 1, 0);
        report();
    end

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(9'h000, v);
            if (!v[0]) break;
        end
    endtask

    task automatic chk_res(input string tag, input int ch);
        logic [15:0] v;
        rd(9'(32 + 2 * ch), v);
        eq(tag, int'(v), int'({4'b0, exp_res[ch]}));
    endtask

    initial begin
        logic [15:0] v;
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(9'h000, v); eq("R1 control after reset", int'(v), 0);
        rd(9'h004, v); eq("R1 channel select after reset", int'(v), 0);
        rd(9'h1F0, v); eq("R1 calibration after reset", int'(v), 0);
        rd(9'h020, v); eq("R1 result ch0 after reset", int'(v), 0);
        eq("R1 irq after reset", int'(irq), 0);
        eq("R1 core_start after reset", int'(core_start), 0);

        // R2 R3 R4 single scan of a sparse bitmap
        wr(9'h004, 16'hA025);
        exp_q = '{0, 2, 5, 13, 15};
        wr(9'h000, 16'h9000);
        wait_idle();
        eq("R2 all channels converted", exp_q.size(), 0);
        chk_res("R2 result ch0", 0);
        chk_res("R2 result ch2", 2);
        chk_res("R2 result ch5", 5);
        chk_res("R2 result ch13", 13);
        chk_res("R2 result ch15", 15);
        rd(9'h022, v); eq("R2 unselected ch1 untouched", int'(v), 0);
        rd(9'h000, v); eq("R3 start bit cleared after single scan", int'(v[15]), 0);
        eq("R4 irq set at scan end", int'(irq), 1);

        // R12 unmapped and odd offsets
        rd(9'h100, v); eq("R12 unmapped offset", int'(v), 0);
        rd(9'h021, v); eq("R12 odd result offset", int'(v), 0);

        // R4 irq clearing and enable
        wr(9'h000, 16'h0000);
        eq("R4 irq cleared by bit12=0", int'(irq), 0);
        wr(9'h004, 16'h0008);
        exp_q = '{3};
        wr(9'h000, 16'h8000);
        wait_idle();
        eq("R4 no irq without enable", int'(irq), 0);
        exp_q = '{3};
        wr(9'h000, 16'h9000);
        wait_idle();
        eq("R4 irq with enable", int'(irq), 1);
        exp_q = '{3};
        wr(9'h000, 16'h9000);
        #1 eq("R4 irq cleared by start write", int'(irq), 0);
        wait_idle();
        eq("R4 irq after restarted scan", int'(irq), 1);
        chk_res("R2 result ch3", 3);

        // R5 empty bitmap
        wr(9'h004, 16'h0000);
        wr(9'h000, 16'h0000);
        base = conv_total;
        wr(9'h000, 16'h9000);
        rd(9'h000, v); eq("R5 start bit clears at once", int'(v[15]), 0);
        repeat (8) @(negedge clk);
        eq("R5 no conversion", conv_total, base);
        eq("R5 no irq", int'(irq), 0);

        // R7 channel-select write during a scan
        wr(9'h004, 16'h0003);
        exp_q = '{0, 1};
        wr(9'h000, 16'h8000);
        wr(9'h004, 16'h0010);
        wait_idle();
        eq("R7 running scan kept old bitmap", exp_q.size(), 0);
        rd(9'h004, v); eq("R7 new bitmap stored", int'(v), 16'h0010);
        exp_q = '{4};
        wr(9'h000, 16'h8000);
        wait_idle();
        eq("R7 next scan used new bitmap", exp_q.size(), 0);
        chk_res("R7 result ch4", 4);

        // R6 continuous mode
        wr(9'h004, 16'h0006);
        exp_q = '{1, 2, 1, 2};
        base = conv_total;
        wr(9'h000, 16'hA000);
        for (int i = 0; i < 200 && conv_total < base + 3; i++) @(negedge clk);
        wr(9'h000, 16'h2000);
        wait_idle();
        eq("R6 two scans then stop", conv_total, base + 4);
        eq("R6 queue drained", exp_q.size(), 0);
        rd(9'h000, v); eq("R6 start bit cleared", int'(v[15]), 0);

        // R8 synchronous trigger
        wr(9'h000, 16'h0000);
        wr(9'h004, 16'h0080);
        base = conv_total;
        @(negedge clk); sync_trig = 1'b1;
        @(negedge clk); sync_trig = 1'b0;
        repeat (8) @(negedge clk);
        eq("R8 trigger ignored when disabled", conv_total, base);
        wr(9'h000, 16'h0100);
        exp_q = '{7};
        @(negedge clk); sync_trig = 1'b1;
        @(negedge clk); sync_trig = 1'b0;
        wait_idle();
        eq("R8 trigger started scan", conv_total, base + 1);
        chk_res("R8 result ch7", 7);

        // R9 external pin
        wr(9'h000, 16'h0000);
        wr(9'h004, 16'h0001);
        base = conv_total;
        @(negedge clk); ext_trig_n = 1'b0;
        repeat (8) @(negedge clk);
        eq("R9 pin ignored when disabled", conv_total, base);
        ext_trig_n = 1'b1;
        repeat (4) @(negedge clk);
        wr(9'h000, 16'h0200);
        exp_q = '{0};
        @(negedge clk); ext_trig_n = 1'b0;
        @(negedge clk); eq("R9 no start one cycle after pin", int'(core_start), 0);
        @(negedge clk); eq("R9 no start two cycles after pin", int'(core_start), 0);
        @(negedge clk); eq("R9 start three cycles after pin", int'(core_start), 1);
        wait_idle();
        eq("R9 pin scan converted", exp_q.size(), 0);
        ext_trig_n = 1'b1;
        chk_res("R9 result ch0", 0);

        // R10 R11 calibration
        wr(9'h000, 16'h0000);
        fail_sel = 1'b0;
        wr(9'h1F0, 16'h0001);
        eq("R10 cal_start pulse", int'(cal_start), 1);
        rd(9'h1F0, v); eq("R10 in progress, not ready", int'(v), 1);
        base = conv_total;
        wr(9'h000, 16'h8000);
        rd(9'h000, v); eq("R11 start ignored during calibration", int'(v[15]), 0);
        repeat (4) @(negedge clk);
        eq("R11 no conversion during calibration", conv_total, base);
        repeat (14) @(negedge clk);
        rd(9'h1F0, v); eq("R10 ready without error", int'(v), 2);
        fail_sel = 1'b1;
        wr(9'h1F0, 16'h0001);
        rd(9'h1F0, v); eq("R10 ready cleared on request", int'(v[1]), 0);
        repeat (16) @(negedge clk);
        rd(9'h1F0, v); eq("R10 ready with error", int'(v), 6);

        eq("R2 scoreboard empty at end", exp_q.size(), 0);
        report();
    end
endmodule